// File: doc/BRIEF.md
# Watchdog Timer with Service Sequence

The block is a watchdog peripheral behind a small 16-bit register port. Once enabled it counts down in half-second steps, derived from a 32 kHz enable pulse, starting from a programmable timeout. When the count runs out it raises a system reset output for a fixed number of slow-clock periods. Software keeps it alive by writing a fixed key pair to the service register. A lock-step software-reset request, a low-power freeze option and a one-shot power-down counter are also provided. The power-down counter pulses an active-low interrupt line unless software switches it off.

Two resets come in. `por` clears everything. `rst` is the system reset and is normally driven from `sys_rst_o` through the reset network. It clears the registers and counters. It does not clear the reset-cause status or the output stretchers, so software can read why the last reset happened.

Top module: `wdog_svc_top`

## Requirements
- R1: After `por`, the registers read as follows: control (offset 0x0) reads 0x0010, status (0x4) reads 0x0000 and power-down control (0x8) reads 0x0001. `sys_rst_o` is 0 and `irq_n_o` is 1. Control encoding: bits 15:8 hold the timeout n, bit 4 reads 1, bit 3 is the timeout-mode select, bit 2 is enable and bit 0 is the freeze option.
- R2: With bit 3 at 0, `sys_rst_o` rises on the (n+1)*DIV_HALF_SEC-th slow tick after enable or after the last valid service, and not earlier.
- R3: Only the write of 0x5555 followed directly by 0xAAAA to the service register (0x2) reloads the count. Either of the following reloads nothing: 0xAAAA written alone, or any other write between the two keys.
- R4: Once enable is set, a control write with bit 2 at 0 leaves it reading 1, and counting goes on.
- R5: A timeout value written while the watchdog runs does not change the count in progress. It is used from the next valid service.
- R6: Bit 0 takes its value from the first control write after reset only. Later writes leave it unchanged. While bit 0 is 1 and `low_power` is 1, slow ticks do not advance the countdown.
- R7: With bit 3 at 1, a timeout drives `irq_n_o` low for RST_HOLD slow ticks instead of raising `sys_rst_o`. The count reloads and runs again.
- R8: `sys_rst_o` stays high for exactly RST_HOLD slow ticks.
- R9: Status bit 1 reads 1 after a timeout reset. Status bit 0 reads 1 after a software reset. Each cause clears the other. The status survives `rst` and is cleared by `por`.
- R10: Two control writes with bit 4 at 0 and no slow tick between them raise `sys_rst_o`. If a slow tick falls between the two writes, no reset results.
- R11: PD_TICKS slow ticks after reset, `irq_n_o` goes low for exactly one clock, and only once. Writing bit 0 of register 0x8 as 0 before then prevents the pulse, and the register then reads 0.
- R12: Read data is valid in the clock after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears all state |
| rst | input | 1 | System reset, synchronous, active high, keeps cause and stretchers |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one clock after the strobe |
| tick_32k | input | 1 | One-clock enable pulse per 32 kHz period |
| low_power | input | 1 | System is in low-power mode |
| sys_rst_o | output | 1 | System reset request, active high |
| irq_n_o | output | 1 | Active-low interrupt / timeout signal |

## Verification
Two situations are hard to reach from the ports. The first is a service pair broken by a stray write that lands just before the count would expire. The second is a timeout that must move by exactly the number of ticks spent frozen in low-power mode. The bench builds both by tracking, in the bench itself, how many slow ticks have passed since the last reload that really took effect. It then mixes random tick gaps, good service pairs and pairs with a random word wedged between the keys, and checks the reset output one tick before and at the predicted expiry. The power-down pulse lasts one clock, so a monitor counts low cycles on the interrupt line rather than sampling it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 16;
  localparam int TOUT_W   = 8;
  localparam int TOUT_LSB = 8;
  localparam int B_FRZ    = 0;
  localparam int B_EN     = 2;
  localparam int B_MODE   = 3;
  localparam int B_SRQ    = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] A_PDC  = 4'h8;

  localparam logic [DATA_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;

  typedef struct packed {
    logic [TOUT_W-1:0] tout;
    logic              mode;
    logic              en;
    logic              frz;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic [1:0]        cause,
  output ctrl_t             ctrl,
  output logic              reload,
  output logic              en_rise,
  output logic              soft_fire,
  output logic              pd_en,
  output logic [DATA_W-1:0] rdata
);
  logic frz_lock, key_armed, srq_armed;
  logic wr_ctrl, wr_svc, wr_pdc;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_svc  = wr && (addr == A_SVC);
  assign wr_pdc  = wr && (addr == A_PDC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      frz_lock  <= 1'b0;
      key_armed <= 1'b0;
      srq_armed <= 1'b0;
      pd_en     <= 1'b1;
      reload    <= 1'b0;
      en_rise   <= 1'b0;
      soft_fire <= 1'b0;
      rdata     <= '0;
    end else begin
      reload    <= 1'b0;
      en_rise   <= 1'b0;
      soft_fire <= 1'b0;
      if (wr_ctrl) begin
        ctrl.tout <= wdata[TOUT_LSB +: TOUT_W];
        ctrl.mode <= wdata[B_MODE];
        if (wdata[B_EN] && !ctrl.en) begin
          ctrl.en <= 1'b1;
          en_rise <= 1'b1;
        end
        if (!frz_lock) ctrl.frz <= wdata[B_FRZ];
        frz_lock <= 1'b1;
      end
      // software reset: two requests inside one slow period
      if (wr_ctrl && !wdata[B_SRQ]) begin
        if (srq_armed && !tick) begin
          soft_fire <= 1'b1;
          srq_armed <= 1'b0;
        end else begin
          srq_armed <= 1'b1;
        end
      end else if (tick) begin
        srq_armed <= 1'b0;
      end
      if (wr_svc) begin
        if (wdata == KEY_ARM) begin
          key_armed <= 1'b1;
        end else begin
          key_armed <= 1'b0;
          if (wdata == KEY_FIRE && key_armed) reload <= 1'b1;
        end
      end
      if (wr_pdc && !wdata[0]) pd_en <= 1'b0;
      if (rd) begin
        case (addr)
          A_CTRL:  rdata <= {ctrl.tout, 3'b000, 1'b1, ctrl.mode, ctrl.en, 1'b0, ctrl.frz};
          A_STAT:  rdata <= {{(DATA_W-2){1'b0}}, cause};
          A_PDC:   rdata <= {{(DATA_W-1){1'b0}}, pd_en};
          default: rdata <= '0;
        endcase
      end
    end
  end

  // R4: enable never falls outside reset
  a_r4_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    ctrl.en |=> ctrl.en);
  // R6: freeze option frozen after first control write
  a_r6_freeze_once: assert property (@(posedge clk) disable iff (rst)
    frz_lock |=> $stable(ctrl.frz));
  // R10: a software reset only follows a request write
  a_r10_soft_cause: assert property (@(posedge clk) disable iff (rst)
    soft_fire |-> $past(wr_ctrl && !wdata[B_SRQ]));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int DIV = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              frozen,
  input  logic              load,
  input  logic [TOUT_W-1:0] tout,
  output logic              expire
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

  logic [PW-1:0]     presc;
  logic [TOUT_W-1:0] cnt;
  logic              adv;

  assign adv = run && tick && !frozen;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc  <= '0;
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        presc <= '0;
        cnt   <= tout;
      end else if (adv) begin
        if (presc == PLAST) begin
          presc <= '0;
          if (cnt == '0) begin
            expire <= 1'b1;
            cnt    <= tout;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          presc <= presc + 1'b1;
        end
      end
    end
  end

  // R3: a reload takes the current timeout and restarts the step
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(tout)) && (presc == '0));
  // R6: nothing moves without an unfrozen tick
  a_r6_hold_still: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(cnt) && $stable(presc));
  // R2: expiry only follows an enabled tick
  a_r2_expire_cause: assert property (@(posedge clk) disable iff (rst)
    expire |-> $past(adv));
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int HOLD = 32
) (
  input  logic clk,
  input  logic clr,
  input  logic trig,
  input  logic tick,
  output logic act
);
  localparam int HW = $clog2(HOLD + 1);
  logic [HW-1:0] left;

  always_ff @(posedge clk) begin
    if (clr) begin
      left <= '0;
      act  <= 1'b0;
    end else if (trig) begin
      left <= HW'(HOLD);
      act  <= 1'b1;
    end else if (tick && left != '0) begin
      left <= left - 1'b1;
      if (left == HW'(1)) act <= 1'b0;
    end
  end

  // R8: the output only ends on a slow tick
  a_r8_hold_on_tick: assert property (@(posedge clk) disable iff (clr)
    (act && !tick) |=> act);
endmodule

// File: rtl/wdog_pdown.sv
module wdog_pdown #(
  parameter int PD_TICKS = 524288
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en,
  output logic pulse
);
  localparam int CW = $clog2(PD_TICKS + 1);
  logic [CW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      done  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (en && !done && tick) begin
        if (cnt == CW'(PD_TICKS - 1)) begin
          pulse <= 1'b1;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R11: the pulse lasts one clock
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/wdog_svc_top.sv
module wdog_svc_top
  import wdog_pkg::*;
#(
  parameter int DIV_HALF_SEC = 16384,
  parameter int RST_HOLD     = 32,
  parameter int PD_TICKS     = 524288
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_32k,
  input  logic              low_power,
  output logic              sys_rst_o,
  output logic              irq_n_o
);
  ctrl_t      ctrl;
  logic       rst_any, reload, en_rise, soft_fire, pd_en, pd_pulse;
  logic       expire, tsig_act;
  logic [1:0] cause;

  assign rst_any = rst | por;

  wdog_regs u_regs (
    .clk(clk), .rst(rst_any), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .tick(tick_32k), .cause(cause), .ctrl(ctrl),
    .reload(reload), .en_rise(en_rise), .soft_fire(soft_fire),
    .pd_en(pd_en), .rdata(reg_rdata)
  );

  wdog_count #(.DIV(DIV_HALF_SEC)) u_count (
    .clk(clk), .rst(rst_any), .run(ctrl.en), .tick(tick_32k),
    .frozen(ctrl.frz && low_power), .load(reload || en_rise),
    .tout(ctrl.tout), .expire(expire)
  );

  wdog_stretch #(.HOLD(RST_HOLD)) u_rst_hold (
    .clk(clk), .clr(por), .trig((expire && !ctrl.mode) || soft_fire),
    .tick(tick_32k), .act(sys_rst_o)
  );

  wdog_stretch #(.HOLD(RST_HOLD)) u_sig_hold (
    .clk(clk), .clr(por), .trig(expire && ctrl.mode),
    .tick(tick_32k), .act(tsig_act)
  );

  wdog_pdown #(.PD_TICKS(PD_TICKS)) u_pdown (
    .clk(clk), .rst(rst_any), .tick(tick_32k), .en(pd_en), .pulse(pd_pulse)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      cause   <= 2'b00;
      irq_n_o <= 1'b1;
    end else begin
      irq_n_o <= !(pd_pulse || tsig_act);
      if (soft_fire)                 cause <= 2'b01;
      else if (expire && !ctrl.mode) cause <= 2'b10;
    end
  end

  // R9: a cause is recorded only alongside a reset request
  a_r9_cause_with_reset: assert property (@(posedge clk) disable iff (por)
    (cause != $past(cause)) |-> sys_rst_o);
endmodule

// File: tb/test_wdog_svc_top.sv
module test_wdog_svc_top;
  localparam int DIV  = 4;
  localparam int HOLD = 3;
  localparam int PD   = 20;

  logic        clk = 1'b0;
  logic        por = 1'b1, rst_tb = 1'b0, rst;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        tick_32k = 1'b0, low_power = 1'b0;
  logic        sys_rst_o, irq_n_o;

  int checks = 0, errors = 0, irq_lows = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign rst = rst_tb | sys_rst_o;

  wdog_svc_top #(.DIV_HALF_SEC(DIV), .RST_HOLD(HOLD), .PD_TICKS(PD)) i_wdog_svc_top (
    .clk(clk), .por(por), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_32k(tick_32k), .low_power(low_power), .sys_rst_o(sys_rst_o),
    .irq_n_o(irq_n_o)
  );

  always @(negedge clk) if (!por && !irq_n_o) irq_lows++;

  function automatic int exp_ticks(int n);
    return (n + 1) * DIV;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic ticks(int k);
    repeat (k) begin
      @(negedge clk); tick_32k = 1'b1;
      @(negedge clk); tick_32k = 1'b0;
      idle(2);
    end
  endtask

  task automatic do_por();
    @(negedge clk); por = 1'b1; idle(3); por = 1'b0; idle(2);
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_tb = 1'b1; idle(2); rst_tb = 1'b0; idle(2);
  endtask

  task automatic wait_hold();
    ticks(HOLD); idle(3);
  endtask

  task automatic setup(int n, logic [7:0] low);
    wr(4'h8, 16'h0000);
    wr(4'h0, {n[7:0], low | 8'h14});
  endtask

  task automatic service();
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int base, el, e, n, k, dl;
    logic [15:0] x;
    void'($urandom(32'h5eed1));
    do_por();

    // R1 / R12 reset state and reads
    chk("R1 rst out", sys_rst_o, 0);
    chk("R1 irq", irq_n_o, 1);
    rd(4'h0, d); chk("R1 ctrl", d, 16'h0010);
    rd(4'h4, d); chk("R1 R12 status", d, 0);
    rd(4'h8, d); chk("R1 R12 pdc", d, 1);

    // R11 power-down pulse
    base = irq_lows;
    ticks(PD - 1); idle(3); chk("R11 early", irq_lows - base, 0);
    ticks(1); idle(3);      chk("R11 pulse", irq_lows - base, 1);
    ticks(PD);              chk("R11 once", irq_lows - base, 1);
    sys_reset();
    wr(4'h8, 16'h0000);
    rd(4'h8, d); chk("R11 pdc off", d, 0);
    base = irq_lows;
    ticks(PD + 4); chk("R11 disabled", irq_lows - base, 0);

    // R2 / R8 / R9 timeout reset
    sys_reset();
    setup(2, 8'h00);
    ticks(exp_ticks(2) - 1); chk("R2 not early", sys_rst_o, 0);
    ticks(1);                chk("R2 expiry", sys_rst_o, 1);
    ticks(HOLD - 1);         chk("R8 held", sys_rst_o, 1);
    ticks(1); idle(3);       chk("R8 released", sys_rst_o, 0);
    rd(4'h4, d); chk("R9 timeout cause", d, 2);
    rd(4'h0, d); chk("R1 ctrl after reset", d, 16'h0010);

    // R3 valid service
    setup(3, 8'h00);
    ticks(10); service();
    ticks(exp_ticks(3) - 1); chk("R3 reloaded", sys_rst_o, 0);
    ticks(1);                chk("R3 expiry after reload", sys_rst_o, 1);
    wait_hold();
    // R3 broken sequences
    setup(3, 8'h00);
    ticks(10);
    wr(4'h2, 16'hAAAA);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    ticks(5); chk("R3 no reload", sys_rst_o, 0);
    ticks(1); chk("R3 original expiry", sys_rst_o, 1);
    wait_hold();

    // R4 enable sticky
    setup(1, 8'h00);
    ticks(3);
    wr(4'h0, 16'h0110);
    rd(4'h0, d); chk("R4 enable reads 1", (d >> 2) & 1, 1);
    ticks(4); chk("R4 still counting", sys_rst_o, 0);
    ticks(1); chk("R4 expiry", sys_rst_o, 1);
    wait_hold();

    // R5 timeout change while running
    setup(1, 8'h00);
    ticks(2);
    wr(4'h0, 16'h0514);
    ticks(5); chk("R5 old count", sys_rst_o, 0);
    ticks(1); chk("R5 old expiry", sys_rst_o, 1);
    wait_hold();
    setup(1, 8'h00);
    wr(4'h0, 16'h0514); service();
    ticks(exp_ticks(5) - 1); chk("R5 new count", sys_rst_o, 0);
    ticks(1);                chk("R5 new expiry", sys_rst_o, 1);
    wait_hold();

    // R6 freeze option
    setup(1, 8'h01);
    wr(4'h0, 16'h0114);
    rd(4'h0, d); chk("R6 frz kept 1", d & 1, 1);
    @(negedge clk); low_power = 1'b1;
    ticks(10);
    @(negedge clk); low_power = 1'b0;
    ticks(7); chk("R6 frozen ticks ignored", sys_rst_o, 0);
    ticks(1); chk("R6 expiry after freeze", sys_rst_o, 1);
    wait_hold();
    setup(1, 8'h00);
    wr(4'h0, 16'h0115);
    rd(4'h0, d); chk("R6 frz kept 0", d & 1, 0);
    @(negedge clk); low_power = 1'b1;
    ticks(7); chk("R6 no freeze early", sys_rst_o, 0);
    ticks(1); chk("R6 no freeze expiry", sys_rst_o, 1);
    @(negedge clk); low_power = 1'b0;
    wait_hold();

    // R7 timeout signal mode
    setup(1, 8'h08);
    ticks(8);
    chk("R7 no reset", sys_rst_o, 0);
    chk("R7 irq low", irq_n_o, 0);
    ticks(HOLD); chk("R7 irq released", irq_n_o, 1);
    ticks(4);    chk("R7 second not early", irq_n_o, 1);
    ticks(1);    chk("R7 second expiry", irq_n_o, 0);
    ticks(HOLD); sys_reset();

    // R10 software reset
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0000); wr(4'h0, 16'h0000); idle(3);
    chk("R10 soft reset", sys_rst_o, 1);
    wait_hold();
    rd(4'h4, d); chk("R9 soft cause", d, 1);
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0000); ticks(1); wr(4'h0, 16'h0000); idle(3);
    chk("R10 split requests", sys_rst_o, 0);
    ticks(2); chk("R10 still no reset", sys_rst_o, 0);
    do_por();
    rd(4'h4, d); chk("R9 cleared by por", d, 0);

    // R2 / R3 random service traffic
    for (int it = 0; it < 20; it++) begin
      n = $urandom_range(0, 12);
      e = exp_ticks(n);
      k = $urandom_range(0, 3);
      el = 0;
      setup(n, 8'h00);
      for (int j = 0; j < k; j++) begin
        if (e - 1 - el >= 1) begin
          dl = $urandom_range(1, e - 1 - el);
          ticks(dl); el += dl;
          if ($urandom_range(0, 1) == 1) begin
            service(); el = 0;
          end else begin
            x = 16'($urandom_range(0, 16'hFFFF));
            if (x == 16'h5555 || x == 16'hAAAA) x = 16'h0001;
            wr(4'h2, 16'h5555); wr(4'h2, x); wr(4'h2, 16'hAAAA);
          end
        end
      end
      ticks(e - 1 - el); chk("R2 R3 random early", sys_rst_o, 0);
      ticks(1);          chk("R2 R3 random expiry", sys_rst_o, 1);
      wait_hold();
      rd(4'h4, d); chk("R9 random cause", d, 2);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule